// File: doc/BRIEF.md
# Keyboard Interrupt Controller

This block gathers nine key inputs into one interrupt request: eight lines of the first general-purpose port and one extra input line. Each line has its own enable bit and the whole unit has a master enable. Every line is brought into the clock domain through two flops. A falling edge on any enabled line, seen while the master enable is on, sets a single request latch. The latch drives the interrupt output until software writes a one to a clear bit.

The block keeps no record of which line fell. Software finds the source by reading the pin levels through the port logic. Enabling a port line for keyboard use also asks the pad logic to force that line to input and to switch on its pull-up. The extra line's pull-up instead follows a static configuration input.

The register interface is a small single-cycle bus. Writes take effect on the clock edge where select and write are both high. Read data is combinational from the address.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: All nine sources (pin_a[7:0] and pin_x) drive the single output irq_req, and edges on several lines at once give the same single request.
- R2: The register at address 0 holds the per-line enables, with bit n enabling pin_a[n]. It reads back the value written.
- R3: Bit 0 of the register at address 1 enables pin_x. Bits 7:1 of that register read 0.
- R4: Bit 7 of the register at address 2 is the master enable. While it is 0, no falling edge sets the request.
- R5: A high-to-low change on an enabled line sets the request. A low-to-high change, or any change on a disabled line, leaves irq_req unchanged.
- R6: Writing 1 to bit 6 of the register at address 2 clears the request in the same write cycle. Writing 0 to that bit has no effect, and the bit always reads 0.
- R7: Once set, irq_req stays at 1 until it is cleared, no matter what the lines do.
- R8: pullup_a and input_force_a equal the per-line enables, independent of the master enable. pullup_x follows xpull_cfg.
- R9: After reset, every enable is 0, irq_req is 0 and every register reads 0.
- R10: If a falling edge and a clear write arrive in the same cycle, the request ends up set.
- R11: Each line passes through a two-flop synchronizer. A line change driven before clock edge k shows up on irq_req after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_a | input | 8 | Port line levels |
| pin_x | input | 1 | Extra line level |
| xpull_cfg | input | 1 | Static pull-up configuration for the extra line |
| irq_req | output | 1 | Latched keyboard request |
| pullup_a | output | 8 | Pull-up request per port line |
| input_force_a | output | 8 | Force-to-input request per port line |
| pullup_x | output | 1 | Pull-up request for the extra line |

## Verification
The following are checked on every cycle by the assertions:
- the request holds until a clear arrives;
- a clear with no concurrent edge drops the request;
- a detected edge always leaves the request set, which covers the case where a clear and an edge collide;
- the request never rises in the cycle after the master enable was low;
- the clear bit reads 0.

Other behaviour can only be shown through the bench's scenarios:
- the exact three-edge latency through the synchronizers;
- rising edges and disabled lines being ignored;
- the mapping of each line to its enable bit;
- register readback and the pull-up outputs.

// File: rtl/kbd_pkg.sv
// Package: shared sizes, register addresses and bit positions for the
// keyboard interrupt controller. Assumes one 8-bit data bus.
package kbd_pkg;
    localparam int KBD_NUM_A  = 8;
    localparam int KBD_DATA_W = 8;
    localparam int KBD_ADDR_W = 2;

    // Mode register bit positions (software depends on these)
    localparam int MODE_MASTER_BIT = 7;
    localparam int MODE_CLEAR_BIT  = 6;
    // Extra-line control register enable position
    localparam int XCTL_EN_BIT     = 0;

    typedef enum logic [KBD_ADDR_W-1:0] {
        ADR_MASK = 2'd0,
        ADR_XCTL = 2'd1,
        ADR_MODE = 2'd2,
        ADR_NONE = 2'd3
    } kbd_addr_e;
endpackage

// File: rtl/kbd_sync.sv
// Module: kbd_sync
// Brings W asynchronous lines into the clk domain with two flops per line.
// Assumes lines idle high (pulled up), so both stages reset to 1 and no
// false falling edge appears when reset is released.
module kbd_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture flop of every line
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                // Purpose: later flops settle any metastable value
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_fall_det.sv
// Module: kbd_fall_det
// Detects a high-to-low change on each synchronized line, masks it with
// that line's enable and ORs all lines into one pulse. The previous-level
// register resets high to match the synchronizer.
module kbd_fall_det #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] en,
    output logic         fall_any
);
    logic [W-1:0] prev_q;
    logic [W-1:0] fall_vec;

    // Purpose: remember last cycle's synchronized level per line
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_line
            assign fall_vec[i] = prev_q[i] & ~lvl[i] & en[i];
        end
    endgenerate

    assign fall_any = |fall_vec;
endmodule

// File: rtl/kbd_req_latch.sv
// Module: kbd_req_latch
// Single shared request latch. It is set by a gated edge pulse and cleared
// by a write-one pulse, and set wins when both arrive together.
module kbd_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);
    logic req_q;

    // Purpose: hold the request; set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)     req_q <= 1'b0;
        else if (set_i) req_q <= 1'b1;
        else if (clr_i) req_q <= 1'b0;
    end

    assign req_o = req_q;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !clr_i) |=> req_o);

    // R6
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !req_o);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> req_o);
endmodule

// File: rtl/kbd_regs.sv
// Module: kbd_regs
// Register file: the port-line enable mask, the extra-line control and the
// mode register (master enable plus a clear bit that is only a pulse).
// Writes need bus_sel and bus_wr in the same cycle. Read data is
// combinational from the address.
module kbd_regs
    import kbd_pkg::*;
#(
    parameter int NUM_A  = KBD_NUM_A,
    parameter int DATA_W = KBD_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [KBD_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_A-1:0]      a_en,
    output logic                  x_en,
    output logic                  master_en,
    output logic                  clr_pulse
);
    logic [NUM_A-1:0] a_en_q;
    logic             x_en_q;
    logic             master_q;
    logic             wr_mask, wr_xctl, wr_mode;
    logic             unused_wbits;

    assign wr_mask = bus_sel && bus_wr && (bus_addr == ADR_MASK);
    assign wr_xctl = bus_sel && bus_wr && (bus_addr == ADR_XCTL);
    assign wr_mode = bus_sel && bus_wr && (bus_addr == ADR_MODE);
    assign unused_wbits = ^bus_wdata;

    // Purpose: per-line enable mask storage
    always_ff @(posedge clk) begin
        if (!rst_n)       a_en_q <= '0;
        else if (wr_mask) a_en_q <= bus_wdata[NUM_A-1:0];
    end

    // Purpose: extra-line enable storage
    always_ff @(posedge clk) begin
        if (!rst_n)       x_en_q <= 1'b0;
        else if (wr_xctl) x_en_q <= bus_wdata[XCTL_EN_BIT];
    end

    // Purpose: master enable storage (clear bit is not stored)
    always_ff @(posedge clk) begin
        if (!rst_n)       master_q <= 1'b0;
        else if (wr_mode) master_q <= bus_wdata[MODE_MASTER_BIT];
    end

    assign clr_pulse = wr_mode && bus_wdata[MODE_CLEAR_BIT];
    assign a_en      = a_en_q;
    assign x_en      = x_en_q;
    assign master_en = master_q;

    // Purpose: read mux; undefined bits and addresses return 0
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MASK: bus_rdata[NUM_A-1:0]      = a_en_q;
            ADR_XCTL: bus_rdata[XCTL_EN_BIT]     = x_en_q;
            ADR_MODE: bus_rdata[MODE_MASTER_BIT] = master_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R6
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_MODE) |-> !bus_rdata[MODE_CLEAR_BIT]);
endmodule

// File: rtl/kbd_irq_ctrl.sv
// Module: kbd_irq_ctrl (top)
// Keyboard interrupt controller: NUM_A port lines plus one extra line,
// synchronized, falling-edge detected, merged into one latched request.
// Assumes lines idle high and that the pad logic acts on the pull-up and
// force-input requests.
module kbd_irq_ctrl
    import kbd_pkg::*;
#(
    parameter int NUM_A  = KBD_NUM_A,
    parameter int DATA_W = KBD_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [KBD_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_A-1:0]      pin_a,
    input  logic                  pin_x,
    input  logic                  xpull_cfg,
    output logic                  irq_req,
    output logic [NUM_A-1:0]      pullup_a,
    output logic [NUM_A-1:0]      input_force_a,
    output logic                  pullup_x
);
    localparam int NSRC = NUM_A + 1;

    logic [NUM_A-1:0] a_en;
    logic             x_en;
    logic             master_en;
    logic             clr_pulse;
    logic [NSRC-1:0]  src_lvl;
    logic [NSRC-1:0]  src_en;
    logic             fall_any;
    logic             set_req;

    kbd_regs #(.NUM_A(NUM_A), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .a_en      (a_en),
        .x_en      (x_en),
        .master_en (master_en),
        .clr_pulse (clr_pulse)
    );

    kbd_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pin_x, pin_a}),
        .dout  (src_lvl)
    );

    assign src_en = {x_en, a_en};

    kbd_fall_det #(.W(NSRC)) u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (src_lvl),
        .en       (src_en),
        .fall_any (fall_any)
    );

    assign set_req = fall_any && master_en;

    kbd_req_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_req),
        .clr_i (clr_pulse),
        .req_o (irq_req)
    );

    // Pad requests: keyboard use implies input mode with pull-up
    assign pullup_a      = a_en;
    assign input_force_a = a_en;
    assign pullup_x      = xpull_cfg;

    // R4
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !$rose(irq_req));
endmodule

// File: tb/kbd_irq_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them on the falling clock edge.
module kbd_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_a = 8'hFF;
    logic       pin_x = 1'b1;
    logic       xpull_cfg = 1'b1;
    logic       irq_req;
    logic [7:0] pullup_a, input_force_a;
    logic       pullup_x;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       irq;
        logic [7:0] pua;
        logic       pux;
        bit         chk_rd;
        logic [7:0] rd;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    kbd_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_a(pin_a), .pin_x(pin_x), .xpull_cfg(xpull_cfg),
        .irq_req(irq_req), .pullup_a(pullup_a),
        .input_force_a(input_force_a), .pullup_x(pullup_x)
    );

    // Monitor: pop and compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (irq_req !== e.irq || pullup_a !== e.pua ||
                    input_force_a !== e.pua || pullup_x !== e.pux ||
                    (e.chk_rd && bus_rdata !== e.rd)) begin
                    errors++;
                    $display("FAIL %s: irq=%b pua=%h frc=%h pux=%b rd=%h | exp irq=%b pua=%h pux=%b rd=%h",
                             e.tag, irq_req, pullup_a, input_force_a, pullup_x,
                             bus_rdata, e.irq, e.pua, e.pux, e.rd);
                end
            end
        end
    end

    logic [7:0] m_en;

    task automatic expect_st(input logic irq, input string tag);
        exp_t e;
        e.irq = irq; e.pua = m_en; e.pux = xpull_cfg;
        e.chk_rd = 1'b0; e.rd = 8'h00; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic irq,
                             input logic [7:0] rd, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a;
        #1;
        e.irq = irq; e.pua = m_en; e.pux = xpull_cfg;
        e.chk_rd = 1'b1; e.rd = rd; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pins(input logic [7:0] a, input logic x);
        @(negedge clk);
        pin_a = a; pin_x = x;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver / scenario
    initial begin
        m_en = 8'h00;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R9 reset state
        expect_st(1'b0, "R9 reset outputs");
        expect_rd(2'd0, 1'b0, 8'h00, "R9 mask resets 0");
        expect_rd(2'd2, 1'b0, 8'h00, "R9 mode resets 0");
        expect_rd(2'd1, 1'b0, 8'h00, "R9 xctl resets 0");

        // R2 R8 enables and pad requests
        wr(2'd0, 8'h05); m_en = 8'h05;
        expect_rd(2'd0, 1'b0, 8'h05, "R2 mask readback, R8 pullups");
        wr(2'd2, 8'hC0);
        expect_rd(2'd2, 1'b0, 8'h80, "R6 clear bit reads 0, R4 master");
        wr(2'd1, 8'hFF);
        expect_rd(2'd1, 1'b0, 8'h01, "R3 xctl upper bits read 0");
        wr(2'd1, 8'h00);

        // R5 disabled line ignored
        pins(8'hFD, 1'b1); cyc(4);
        expect_st(1'b0, "R5 disabled line");
        pins(8'hFF, 1'b1); cyc(4);

        // R11 latency, R5 falling edge sets
        pins(8'hFB, 1'b1); cyc(2);
        expect_st(1'b0, "R11 not before third edge");
        cyc(1);
        expect_st(1'b1, "R11 R5 set after third edge");
        pins(8'hFF, 1'b1); cyc(20);
        expect_st(1'b1, "R7 request holds");
        wr(2'd2, 8'h80);
        expect_st(1'b1, "R6 writing 0 to clear bit");
        wr(2'd2, 8'hC0);
        expect_st(1'b0, "R6 clear");
        expect_rd(2'd2, 1'b0, 8'h80, "R6 clear bit reads 0 after clear");

        // R5 rising edge ignored
        pins(8'hFB, 1'b1); cyc(4);
        wr(2'd2, 8'hC0);
        pins(8'hFF, 1'b1); cyc(4);
        expect_st(1'b0, "R5 rising edge ignored");

        // R3 extra line
        pins(8'hFF, 1'b0); cyc(4);
        expect_st(1'b0, "R3 extra line disabled");
        pins(8'hFF, 1'b1); cyc(4);
        wr(2'd1, 8'h01);
        pins(8'hFF, 1'b0); cyc(4);
        expect_st(1'b1, "R3 extra line sets request");
        pins(8'hFF, 1'b1); cyc(4);
        wr(2'd2, 8'hC0);
        expect_st(1'b0, "R6 clear after extra line");

        // R1 several lines at once give one request, one clear suffices
        pins(8'hFA, 1'b0); cyc(4);
        expect_st(1'b1, "R1 shared request");
        wr(2'd2, 8'hC0);
        expect_st(1'b0, "R1 single clear");
        pins(8'hFF, 1'b1); cyc(4);

        // R4 master off blocks edges
        wr(2'd2, 8'h00);
        pins(8'hFE, 1'b1); cyc(4);
        expect_st(1'b0, "R4 master off, R8 pullups kept");
        wr(2'd2, 8'h80); cyc(4);
        expect_st(1'b0, "R4 no late set after master on");
        pins(8'hFF, 1'b1); cyc(4);

        // R10 edge and clear in same cycle
        pins(8'hFE, 1'b1);
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hC0;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        expect_st(1'b1, "R10 set wins over clear");
        wr(2'd2, 8'hC0);
        expect_st(1'b0, "R10 later clear works");
        pins(8'hFF, 1'b1); cyc(4);

        // R8 extra pull-up follows config
        @(negedge clk); xpull_cfg = 1'b0; #1;
        expect_st(1'b0, "R8 pullup_x follows config");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule